// File: doc/BRIEF.md
# Slot-to-Channel Map Controller

This block keeps the table that tells a time-division framer which logical channel owns each of the 32 slots in a frame. Each table entry holds a 5-bit channel number and an 8-bit mask. The mask marks which bit positions inside the slot carry that channel. The host never addresses the table directly. It loads a data register with a channel and mask. It then writes a command register that names a slot and selects store, fetch or bulk fill. The framer-side logic reads any entry at any time through a combinational lookup port.

A bulk fill runs one slot per clock from slot 0 to slot 31. It writes the data register's mask into every entry and writes each entry's own slot number as its channel. While the fill runs, the block asserts a reset request to the downstream transmit/receive framing, DMA and line-interface controllers. A fill starts on a pin reset, on a software reset, or on a 0-to-1 change of the command register's fill bit. A command write with the fill bit at 0 stops a fill that is running.

Top module: `tsa_slot_map`

## Requirements
- R1: After pin reset the command register reads 0x0000, the data register reads 0x0100, the fill is running, the fill-done flag is 0 and the downstream reset request is 1.
- R2: A pin reset, or a software reset held for one clock, restores both registers to their reset values and starts a fill. Thirty-two clocks later every entry holds channel = slot index and mask = 0x00.
- R3: A command write (select 0) whose bit 6 is 1, when the stored bit 6 is 0 and no fill is running, starts a fill. It does no store or fetch. The fill writes one entry per clock in slot order 0..31. Each entry gets channel = slot index and mask = data register bits 7:0. The done flag rises on the clock that writes slot 31, and the fill flag falls on that same clock.
- R4: The downstream reset request is 1 on exactly the clocks on which a fill is running, which is 32 clocks for an uninterrupted fill.
- R5: When no fill runs and no fill starts, a command write with bit 5 = 0 stores data register bits 12:8 as the channel and bits 7:0 as the mask into the slot named by command bits 4:0.
- R6: When no fill runs and no fill starts, a command write with bit 5 = 1 loads the named entry into the data register on the same clock, with the channel in bits 12:8 and the mask in bits 7:0.
- R7: A data register write (select 1) while no fill runs keeps bits 12:0 and forces bits 15:13 to 0.
- R8: While a fill runs, data register writes and command writes with bit 6 = 1 are ignored. The data register, the command register and the table outcome are unchanged.
- R9: A command write with bit 6 = 0 during a fill stops it on that clock. The slot being written on that clock is still written and no later slot is written. The fill flag, the done flag and the downstream reset request all drop, and no fetch or store takes place.
- R10: Rewriting the command register with bit 6 = 1 while the stored bit 6 is already 1 does not restart the fill. It acts as an ordinary store or fetch.
- R11: The done flag is cleared when a new fill starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low pin reset |
| sw_rst_i | input | 1 | Synchronous software reset, active high |
| host_wr_i | input | 1 | Host register write strobe |
| host_sel_i | input | 1 | 0 selects the command register, 1 selects the data register |
| host_wdata_i | input | 16 | Host write data |
| cmd_reg_o | output | 16 | Command register contents (bits 4:0 slot, 5 fetch, 6 fill) |
| data_reg_o | output | 16 | Data register contents (bits 12:8 channel, 7:0 mask) |
| lu_slot_i | input | 5 | Lookup slot index from the framer |
| lu_chan_o | output | 5 | Channel number of the looked-up slot |
| lu_mask_o | output | 8 | Bit mask of the looked-up slot |
| fill_busy_o | output | 1 | Bulk fill running |
| fill_done_o | output | 1 | Last bulk fill reached slot 31 |
| ds_reset_o | output | 1 | Reset request to downstream controllers |

## Verification
A wrong slot pointer or fill length shows up first at the fill flag and the downstream reset request. These fall one clock early or late against the 32-clock count. A misplaced pointer then shows at the lookup port as a channel field that differs from its slot index. A fill that fails to freeze host writes, or a stop that fails to halt the pointer, changes the data register, or changes a mask at a slot beyond the stop point. This is visible on the first lookup after the stop. Fetch and store path faults appear on the clock after the command write, on the data register or on the lookup of the named slot.

// File: rtl/tsa_pkg.sv
package tsa_pkg;

   typedef enum logic {
      HOST_SEL_CMD  = 1'b0,
      HOST_SEL_DATA = 1'b1
   } host_sel_e;

   typedef enum logic [1:0] {
      FILL_IDLE = 2'd0,
      FILL_RUN  = 2'd1,
      FILL_DONE = 2'd2
   } fill_state_e;

endpackage

// File: rtl/tsa_map_mem.sv
module tsa_map_mem #(
   parameter int NUM_SLOTS = 32,
   parameter int MASK_W    = 8,
   parameter bit USE_FLOPS = 1'b1,
   localparam int SLOT_W   = $clog2(NUM_SLOTS),
   localparam int ENTRY_W  = SLOT_W + MASK_W
) (
   input  logic              clk,
   input  logic              we,
   input  logic [SLOT_W-1:0] waddr,
   input  logic [SLOT_W-1:0] wchan,
   input  logic [MASK_W-1:0] wmask,
   input  logic [SLOT_W-1:0] ra_slot,
   output logic [SLOT_W-1:0] ra_chan,
   output logic [MASK_W-1:0] ra_mask,
   input  logic [SLOT_W-1:0] rb_slot,
   output logic [SLOT_W-1:0] rb_chan,
   output logic [MASK_W-1:0] rb_mask
);

   logic [ENTRY_W-1:0] wword;
   logic [ENTRY_W-1:0] ent [NUM_SLOTS];

   assign wword = {wchan, wmask};

   if (USE_FLOPS) begin : g_flops
      for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_ent
         logic [ENTRY_W-1:0] q;
         always_ff @(posedge clk) begin
            if (we && (waddr == SLOT_W'(i))) begin
               q <= wword;
            end
         end
         assign ent[i] = q;
      end
   end else begin : g_array
      logic [ENTRY_W-1:0] arr [NUM_SLOTS];
      always_ff @(posedge clk) begin
         if (we) begin
            arr[waddr] <= wword;
         end
      end
      for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_rd
         assign ent[i] = arr[i];
      end
   end

   assign {ra_chan, ra_mask} = ent[ra_slot];
   assign {rb_chan, rb_mask} = ent[rb_slot];

endmodule

// File: rtl/tsa_fill_seq.sv
module tsa_fill_seq
   import tsa_pkg::*;
#(
   parameter int NUM_SLOTS = 32,
   localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_rst,
   input  logic              start,
   input  logic              stop,
   output logic              busy_o,
   output logic              done_o,
   output logic [SLOT_W-1:0] ptr_o
);

   localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

   fill_state_e       st_q;
   logic [SLOT_W-1:0] ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= FILL_RUN;
         ptr_q <= '0;
      end else if (sw_rst) begin
         st_q  <= FILL_RUN;
         ptr_q <= '0;
      end else begin
         unique case (st_q)
            FILL_RUN: begin
               ptr_q <= ptr_q + SLOT_W'(1);
               if (stop) begin
                  st_q <= FILL_IDLE;
               end else if (ptr_q == LAST_SLOT) begin
                  st_q <= FILL_DONE;
               end
            end
            default: begin
               if (start) begin
                  st_q  <= FILL_RUN;
                  ptr_q <= '0;
               end
            end
         endcase
      end
   end

   assign busy_o = (st_q == FILL_RUN);
   assign done_o = (st_q == FILL_DONE);
   assign ptr_o  = ptr_q;

endmodule

// File: rtl/tsa_host_regs.sv
module tsa_host_regs
   import tsa_pkg::*;
#(
   parameter int SLOT_W    = 5,
   parameter int MASK_W    = 8,
   parameter int REG_W     = 16,
   localparam int ENTRY_W  = SLOT_W + MASK_W,
   localparam int RD_BIT   = SLOT_W,
   localparam int FILL_BIT = SLOT_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_rst,
   input  logic              host_wr,
   input  logic              host_sel,
   input  logic [REG_W-1:0]  host_wdata,
   input  logic              busy,
   input  logic [SLOT_W-1:0] rd_chan,
   input  logic [MASK_W-1:0] rd_mask,
   output logic [REG_W-1:0]  cmd_q_o,
   output logic [REG_W-1:0]  data_q_o,
   output logic              start_o,
   output logic              stop_o,
   output logic              acc_we_o,
   output logic [SLOT_W-1:0] acc_slot_o,
   output logic [SLOT_W-1:0] data_chan_o,
   output logic [MASK_W-1:0] data_mask_o
);

   localparam logic [REG_W-1:0] CMD_KEEP  = REG_W'((1 << (SLOT_W + 2)) - 1);
   localparam logic [REG_W-1:0] DATA_KEEP = REG_W'((1 << ENTRY_W) - 1);
   localparam logic [REG_W-1:0] DATA_RST  = REG_W'(1 << MASK_W);

   logic             wr_ok;
   logic             cmd_wr;
   logic             data_wr;
   logic             new_fill;
   logic             old_fill;
   logic             acc;
   logic             acc_rd;
   logic [REG_W-1:0] rd_word;
   logic [REG_W-1:0] cmd_q;
   logic [REG_W-1:0] data_q;

   assign wr_ok    = host_wr && !sw_rst;
   assign cmd_wr   = wr_ok && (host_sel == HOST_SEL_CMD);
   assign data_wr  = wr_ok && (host_sel == HOST_SEL_DATA);
   assign new_fill = host_wdata[FILL_BIT];
   assign old_fill = cmd_q[FILL_BIT];

   assign start_o  = cmd_wr && !busy && new_fill && !old_fill;
   assign stop_o   = cmd_wr && busy && !new_fill;
   assign acc      = cmd_wr && !busy && !start_o;
   assign acc_rd   = acc && host_wdata[RD_BIT];
   assign acc_we_o = acc && !host_wdata[RD_BIT];

   assign acc_slot_o = host_wdata[SLOT_W-1:0];
   assign rd_word    = REG_W'({rd_chan, rd_mask});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q  <= '0;
         data_q <= DATA_RST;
      end else if (sw_rst) begin
         cmd_q  <= '0;
         data_q <= DATA_RST;
      end else begin
         if (cmd_wr && (!busy || stop_o)) begin
            cmd_q <= host_wdata & CMD_KEEP;
         end
         if (data_wr && !busy) begin
            data_q <= host_wdata & DATA_KEEP;
         end else if (acc_rd) begin
            data_q <= rd_word;
         end
      end
   end

   assign cmd_q_o     = cmd_q;
   assign data_q_o    = data_q;
   assign data_chan_o = data_q[ENTRY_W-1:MASK_W];
   assign data_mask_o = data_q[MASK_W-1:0];

endmodule

// File: rtl/tsa_slot_map.sv
module tsa_slot_map
   import tsa_pkg::*;
#(
   parameter int NUM_SLOTS = 32,
   parameter int MASK_W    = 8,
   parameter int REG_W     = 16,
   parameter bit USE_FLOPS = 1'b1,
   localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_rst_i,
   input  logic              host_wr_i,
   input  logic              host_sel_i,
   input  logic [REG_W-1:0]  host_wdata_i,
   output logic [REG_W-1:0]  cmd_reg_o,
   output logic [REG_W-1:0]  data_reg_o,
   input  logic [SLOT_W-1:0] lu_slot_i,
   output logic [SLOT_W-1:0] lu_chan_o,
   output logic [MASK_W-1:0] lu_mask_o,
   output logic              fill_busy_o,
   output logic              fill_done_o,
   output logic              ds_reset_o
);

   if (NUM_SLOTS < 2 || (NUM_SLOTS & (NUM_SLOTS - 1)) != 0) begin : g_bad_slots
      $error("tsa_slot_map: NUM_SLOTS must be a power of two of at least 2");
   end
   if (MASK_W < 1) begin : g_bad_mask
      $error("tsa_slot_map: MASK_W must be at least 1");
   end
   if (REG_W < SLOT_W + 2 || REG_W < SLOT_W + MASK_W) begin : g_bad_reg
      $error("tsa_slot_map: REG_W too narrow for the register fields");
   end

   logic              busy;
   logic              done;
   logic [SLOT_W-1:0] ptr;
   logic              start;
   logic              stop;
   logic              acc_we;
   logic [SLOT_W-1:0] acc_slot;
   logic [SLOT_W-1:0] data_chan;
   logic [MASK_W-1:0] data_mask;
   logic [SLOT_W-1:0] rd_chan;
   logic [MASK_W-1:0] rd_mask;
   logic              mem_we;
   logic [SLOT_W-1:0] mem_waddr;
   logic [SLOT_W-1:0] mem_wchan;

   tsa_host_regs #(
      .SLOT_W (SLOT_W),
      .MASK_W (MASK_W),
      .REG_W  (REG_W)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .sw_rst      (sw_rst_i),
      .host_wr     (host_wr_i),
      .host_sel    (host_sel_i),
      .host_wdata  (host_wdata_i),
      .busy        (busy),
      .rd_chan     (rd_chan),
      .rd_mask     (rd_mask),
      .cmd_q_o     (cmd_reg_o),
      .data_q_o    (data_reg_o),
      .start_o     (start),
      .stop_o      (stop),
      .acc_we_o    (acc_we),
      .acc_slot_o  (acc_slot),
      .data_chan_o (data_chan),
      .data_mask_o (data_mask)
   );

   tsa_fill_seq #(
      .NUM_SLOTS (NUM_SLOTS)
   ) u_fill (
      .clk    (clk),
      .rst_n  (rst_n),
      .sw_rst (sw_rst_i),
      .start  (start),
      .stop   (stop),
      .busy_o (busy),
      .done_o (done),
      .ptr_o  (ptr)
   );

   // Fill has the write port whenever it runs; host stores only when idle.
   assign mem_we    = busy || acc_we;
   assign mem_waddr = busy ? ptr : acc_slot;
   assign mem_wchan = busy ? ptr : data_chan;

   tsa_map_mem #(
      .NUM_SLOTS (NUM_SLOTS),
      .MASK_W    (MASK_W),
      .USE_FLOPS (USE_FLOPS)
   ) u_mem (
      .clk     (clk),
      .we      (mem_we),
      .waddr   (mem_waddr),
      .wchan   (mem_wchan),
      .wmask   (data_mask),
      .ra_slot (acc_slot),
      .ra_chan (rd_chan),
      .ra_mask (rd_mask),
      .rb_slot (lu_slot_i),
      .rb_chan (lu_chan_o),
      .rb_mask (lu_mask_o)
   );

   assign fill_busy_o = busy;
   assign fill_done_o = done;
   assign ds_reset_o  = busy;

endmodule

// File: rtl/tsa_slot_map_chk.sv
module tsa_slot_map_chk #(
   parameter int NUM_SLOTS = 32,
   parameter int MASK_W    = 8,
   parameter int REG_W     = 16,
   localparam int SLOT_W   = $clog2(NUM_SLOTS),
   localparam int ENTRY_W  = SLOT_W + MASK_W,
   localparam int FILL_BIT = SLOT_W + 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sw_rst_i,
   input logic             host_wr_i,
   input logic             host_sel_i,
   input logic [REG_W-1:0] host_wdata_i,
   input logic [REG_W-1:0] cmd_reg_o,
   input logic [REG_W-1:0] data_reg_o,
   input logic             fill_busy_o,
   input logic             fill_done_o
);

   localparam logic [REG_W-1:0] DATA_RST = REG_W'(1 << MASK_W);

   AST_SWRST_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
      sw_rst_i |=> fill_busy_o && !fill_done_o && (cmd_reg_o == '0) && (data_reg_o == DATA_RST)); // R2

   AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(fill_busy_o && fill_done_o)); // R3

   AST_FILL_START: assert property (@(posedge clk) disable iff (!rst_n)
      !fill_busy_o && !sw_rst_i && host_wr_i && !host_sel_i && host_wdata_i[FILL_BIT]
      && !cmd_reg_o[FILL_BIT] |=> fill_busy_o && !fill_done_o); // R11

   AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (data_reg_o >> ENTRY_W) == '0); // R7

   AST_DATA_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      fill_busy_o && !sw_rst_i |=> $stable(data_reg_o)); // R8

   AST_STOP_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      fill_busy_o && !sw_rst_i && host_wr_i && !host_sel_i && !host_wdata_i[FILL_BIT]
      |=> !fill_busy_o && !fill_done_o); // R9

   AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      !fill_busy_o && !sw_rst_i && cmd_reg_o[FILL_BIT] && host_wr_i && !host_sel_i
      |=> !fill_busy_o); // R10

endmodule

bind tsa_slot_map tsa_slot_map_chk #(
   .NUM_SLOTS (NUM_SLOTS),
   .MASK_W    (MASK_W),
   .REG_W     (REG_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .sw_rst_i     (sw_rst_i),
   .host_wr_i    (host_wr_i),
   .host_sel_i   (host_sel_i),
   .host_wdata_i (host_wdata_i),
   .cmd_reg_o    (cmd_reg_o),
   .data_reg_o   (data_reg_o),
   .fill_busy_o  (fill_busy_o),
   .fill_done_o  (fill_done_o)
);

// File: tb/tsa_slot_map_tb_top.sv
`timescale 1ns/100ps
module tsa_slot_map_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sw_rst = 1'b0;
   logic        host_wr = 1'b0;
   logic        host_sel = 1'b0;
   logic [15:0] host_wdata = '0;
   logic [15:0] cmd_reg;
   logic [15:0] data_reg;
   logic [4:0]  lu_slot = '0;
   logic [4:0]  lu_chan;
   logic [7:0]  lu_mask;
   logic        busy;
   logic        done;
   logic        ds_rst;

   int n_tests = 0;
   int n_fail  = 0;

   logic [4:0]  m_chan [32];
   logic [7:0]  m_mask [32];
   logic [15:0] m_data;
   logic [15:0] m_cmd;

   always #2 clk = ~clk;

   tsa_slot_map dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .sw_rst_i     (sw_rst),
      .host_wr_i    (host_wr),
      .host_sel_i   (host_sel),
      .host_wdata_i (host_wdata),
      .cmd_reg_o    (cmd_reg),
      .data_reg_o   (data_reg),
      .lu_slot_i    (lu_slot),
      .lu_chan_o    (lu_chan),
      .lu_mask_o    (lu_mask),
      .fill_busy_o  (busy),
      .fill_done_o  (done),
      .ds_reset_o   (ds_rst)
   );

   function automatic logic [15:0] f_cmd(input int slot, input bit rd, input bit fill);
      return 16'((int'(fill) << 6) | (int'(rd) << 5) | (slot & 31));
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic model_fill(input int upto);
      for (int i = 0; i <= upto; i++) begin
         m_chan[i] = 5'(i);
         m_mask[i] = m_data[7:0];
      end
   endtask

   task automatic wr_reg(input logic sel, input logic [15:0] v);
      host_wr = 1'b1;
      host_sel = sel;
      host_wdata = v;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic chk_map(input string req);
      for (int i = 0; i < 32; i++) begin
         lu_slot = 5'(i);
         #1;
         chk(req, {27'd0, lu_chan}, {27'd0, m_chan[i]});
         chk(req, {24'd0, lu_mask}, {24'd0, m_mask[i]});
         @(negedge clk);
      end
   endtask

   task automatic wait_full_fill(input string req);
      repeat (31) @(negedge clk);
      chk(req, {31'd0, ds_rst}, 32'd1);
      chk(req, {31'd0, busy}, 32'd1);
      @(negedge clk);
      chk(req, {31'd0, busy}, 32'd0);
      chk(req, {31'd0, done}, 32'd1);
      chk(req, {31'd0, ds_rst}, 32'd0);
   endtask

   initial begin
      #800000;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      int seed;
      seed = $urandom(32'h1357_2468);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1 cmd", {16'd0, cmd_reg}, 32'h0);
      chk("R1 data", {16'd0, data_reg}, 32'h0100);
      chk("R1 busy", {31'd0, busy}, 32'd1);
      chk("R1 done", {31'd0, done}, 32'd0);
      chk("R1 dsrst", {31'd0, ds_rst}, 32'd1);
      m_data = 16'h0100;
      m_cmd = 16'h0;
      // R2 R4 fill after pin reset
      wait_full_fill("R2 R4 pin reset fill");
      model_fill(31);
      chk_map("R2 map after pin reset");

      // R7 reserved bits
      wr_reg(1'b1, 16'hFFFF);
      m_data = 16'h1FFF;
      chk("R7 data mask", {16'd0, data_reg}, 32'h1FFF);
      // R5 store
      wr_reg(1'b0, f_cmd(5, 1'b0, 1'b0));
      m_chan[5] = 5'h1F; m_mask[5] = 8'hFF;
      lu_slot = 5'd5; #1;
      chk("R5 chan", {27'd0, lu_chan}, 32'h1F);
      chk("R5 mask", {24'd0, lu_mask}, 32'hFF);
      @(negedge clk);
      // R6 fetch
      wr_reg(1'b1, 16'h0000);
      wr_reg(1'b0, f_cmd(5, 1'b1, 1'b0));
      chk("R6 fetch", {16'd0, data_reg}, 32'h1FFF);
      m_data = 16'h1FFF;

      // R3 fill start with mask A5, R8 ignored commands
      wr_reg(1'b1, 16'h00A5);
      m_data = 16'h00A5;
      wr_reg(1'b0, f_cmd(3, 1'b0, 1'b1));
      chk("R3 busy after start", {31'd0, busy}, 32'd1);
      chk("R3 dsrst after start", {31'd0, ds_rst}, 32'd1);
      wr_reg(1'b1, 16'h1234);
      wr_reg(1'b0, f_cmd(9, 1'b1, 1'b1));
      chk("R8 data unchanged", {16'd0, data_reg}, 32'h00A5);
      chk("R8 cmd unchanged", {16'd0, cmd_reg}, {16'd0, f_cmd(3, 1'b0, 1'b1)});
      repeat (29) @(negedge clk);
      chk("R4 busy at clock 31", {31'd0, busy}, 32'd1);
      @(negedge clk);
      chk("R3 done", {31'd0, done}, 32'd1);
      chk("R3 busy low", {31'd0, busy}, 32'd0);
      model_fill(31);
      chk_map("R3 R8 map after fill");

      // R10 fill bit held at 1 is an ordinary store
      wr_reg(1'b1, 16'h0C3C);
      m_data = 16'h0C3C;
      wr_reg(1'b0, f_cmd(7, 1'b0, 1'b1));
      m_chan[7] = 5'h0C; m_mask[7] = 8'h3C;
      chk("R10 no restart", {31'd0, busy}, 32'd0);
      chk("R10 done kept", {31'd0, done}, 32'd1);
      lu_slot = 5'd7; #1;
      chk("R10 store chan", {27'd0, lu_chan}, 32'h0C);
      chk("R10 store mask", {24'd0, lu_mask}, 32'h3C);
      @(negedge clk);
      wr_reg(1'b1, 16'h0000);
      wr_reg(1'b0, f_cmd(7, 1'b1, 1'b0));
      chk("R6 fetch slot 7", {16'd0, data_reg}, 32'h0C3C);

      // R11 done cleared, R9 stop mid fill
      wr_reg(1'b1, 16'h0011);
      m_data = 16'h0011;
      wr_reg(1'b0, f_cmd(0, 1'b0, 1'b1));
      chk("R11 done cleared", {31'd0, done}, 32'd0);
      chk("R11 busy", {31'd0, busy}, 32'd1);
      repeat (9) @(negedge clk);
      wr_reg(1'b0, f_cmd(4, 1'b1, 1'b0));
      model_fill(9);
      chk("R9 busy low", {31'd0, busy}, 32'd0);
      chk("R9 done low", {31'd0, done}, 32'd0);
      chk("R9 dsrst low", {31'd0, ds_rst}, 32'd0);
      chk("R9 no fetch", {16'd0, data_reg}, 32'h0011);
      repeat (3) @(negedge clk);
      chk("R9 stays stopped", {31'd0, busy}, 32'd0);
      chk_map("R9 map after stop");

      // R2 software reset
      sw_rst = 1'b1;
      @(negedge clk);
      sw_rst = 1'b0;
      chk("R2 sw busy", {31'd0, busy}, 32'd1);
      chk("R2 sw data", {16'd0, data_reg}, 32'h0100);
      chk("R2 sw cmd", {16'd0, cmd_reg}, 32'h0);
      m_data = 16'h0100;
      wait_full_fill("R2 R4 soft reset fill");
      model_fill(31);
      chk_map("R2 map after soft reset");

      // random store / fetch / data writes, R5 R6 R7
      for (int it = 0; it < 400; it++) begin
         int op;
         int slot;
         logic [15:0] v;
         op = int'($urandom % 3);
         slot = int'($urandom % 32);
         v = 16'($urandom);
         if (op == 0) begin
            wr_reg(1'b1, v);
            m_data = v & 16'h1FFF;
            chk("R7 random data", {16'd0, data_reg}, {16'd0, m_data});
         end else if (op == 1) begin
            wr_reg(1'b0, f_cmd(slot, 1'b0, 1'b0));
            m_chan[slot] = m_data[12:8];
            m_mask[slot] = m_data[7:0];
            lu_slot = 5'(slot); #1;
            chk("R5 random store", {19'd0, lu_chan, lu_mask}, {19'd0, m_chan[slot], m_mask[slot]});
         end else begin
            wr_reg(1'b0, f_cmd(slot, 1'b1, 1'b0));
            m_data = {3'd0, m_chan[slot], m_mask[slot]};
            chk("R6 random fetch", {16'd0, data_reg}, {16'd0, m_data});
         end
         chk("R5 random no fill", {31'd0, busy}, 32'd0);
      end
      chk_map("R5 map after random phase");

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule